// File: doc/BRIEF.md
# PCI Target Command Decoder with Burst Disconnect

This block is the front end of a PCI target. In the address phase it looks at the bus command nibble and at a one-hot vector of region hits, which an address comparator outside the block produces. From these it decides whether to claim the cycle. It folds the extended memory commands into plain reads and writes, and it records which region was hit.

During the data phases it drives the target-ready and stop signals. Register and ROM regions never burst. Memory accesses whose burst ordering is not linear are also cut short. In both cases the block completes the first data phase with ready and stop together, which is a disconnect with data. A back-end strobe reports every data phase that completes, together with the normalized operation, the space and the region index.

The block itself has no data path. Parity, DEVSEL timing and the address comparison belong to neighbouring logic.

Top module: `pci_tgt_cmd_ctl`

## Requirements
- R1: An address phase is the first cycle in which `bus_active_n` is low after a cycle in which it was high, while the block is idle. The block claims the cycle (`owned` high from the next cycle) for codes 0010 and 0011 (I/O read and write), 0110 and 0111 (memory read and write) and 1010 and 1011 (configuration read and write), but only if at least one `region_hit` bit is set.
- R2: The block ignores codes 0000, 0001, 0100, 0101, 1000, 1001 and 1101. `owned` stays low, and `tgt_ready_n` and `disc_req_n` stay high for the whole cycle, whatever the hits are.
- R3: Codes 1100 and 1110 are claimed, and every data phase is reported as a memory read (`be_write`=0, `be_space`=00).
- R4: Code 1111 is claimed, and every data phase is reported as a memory write (`be_write`=1, `be_space`=00).
- R5: With no `region_hit` bit set, no cycle is claimed. Otherwise `be_region` is the index of the lowest set hit bit. Bit 0 is configuration, bit 1 is the operation registers, bit 2 is the expansion ROM, and bits 3 to 6 are base regions 1 to 4.
- R6: `be_strobe` is high in exactly those cycles in which `tgt_ready_n` and `init_ready_n` are both low. While it is high, `be_write` equals bit 0 of the command code. `be_space` is 01 for I/O codes, 10 for configuration codes and 00 for memory codes.
- R7: On a claimed access to regions 3 to 6 with linear ordering, `tgt_ready_n` is low in every data phase from the cycle after the address phase onward, and `disc_req_n` stays high. Wait states from `init_ready_n` are honoured.
- R8: On a claimed access to regions 0 to 2, `disc_req_n` is low together with `tgt_ready_n` in the first data phase, whether the initiator asks for one phase or several.
- R9: Memory codes with `addr_lo` other than 00 (non-linear ordering) disconnect in the first data phase as in R8. For I/O and configuration codes, `addr_lo` has no effect.
- R10: If the initiator keeps `bus_active_n` low after a disconnected first phase, `tgt_ready_n` goes high, so no further data transfers and no strobe is raised. `disc_req_n` stays low until a phase completes with `bus_active_n` high and `init_ready_n` low.
- R11: After the final data phase completes (`bus_active_n` high, `init_ready_n` low), `owned` drops on the next cycle, and `tgt_ready_n` and `disc_req_n` return high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| bus_active_n | input | 1 | Initiator cycle framing, active low |
| init_ready_n | input | 1 | Initiator ready, active low |
| cmd_be_n | input | 4 | Command in the address phase |
| addr_lo | input | 2 | Low address bits in the address phase (burst ordering) |
| region_hit | input | NREG | One-hot region hits from the address comparator |
| owned | output | 1 | Block has claimed the current cycle |
| tgt_ready_n | output | 1 | Target ready, active low |
| disc_req_n | output | 1 | Target stop request, active low |
| be_strobe | output | 1 | One data phase completes |
| be_write | output | 1 | Normalized operation: 1 write, 0 read |
| be_space | output | 2 | 00 memory, 01 I/O, 10 configuration |
| be_region | output | $clog2(NREG) | Index of the hit region |

## Verification
All 16 command codes are crossed with every single region hit, with no hit, and with two multi-hit vectors. This separates the claimed codes from the ignored ones and checks the lowest-bit region priority. Each combination runs with ordering bits 00, 01 and 10. This shows the ordering bits acting only on memory codes. Each combination also runs as a single-phase and a three-phase transfer, which separates a correct disconnect-with-data, and the stop held afterwards, from a burst that runs through. The cases with ordering 01 add a wait state before the first phase, so the bench can confirm that no strobe is raised while the initiator is not ready.

// File: rtl/pci_tgt_cmd_ctl.sv
module pci_tgt_cmd_ctl #(
  parameter int NREG    = 7,
  parameter int NOBURST = 3,
  localparam int RW     = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_active_n,
  input  logic            init_ready_n,
  input  logic [3:0]      cmd_be_n,
  input  logic [1:0]      addr_lo,
  input  logic [NREG-1:0] region_hit,
  output logic            owned,
  output logic            tgt_ready_n,
  output logic            disc_req_n,
  output logic            be_strobe,
  output logic            be_write,
  output logic [1:0]      be_space,
  output logic [RW-1:0]   be_region
);

  localparam logic [1:0] SP_MEM = 2'b00;
  localparam logic [1:0] SP_IO  = 2'b01;
  localparam logic [1:0] SP_CFG = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_HOLD} st_t;
  st_t st;

  logic          frame_q, disc_q, cmd_ok, no_burst, addr_phase, take;
  logic [1:0]    cmd_sp;
  logic [RW-1:0] hit_idx;

  always_comb begin
    cmd_ok = 1'b0;
    cmd_sp = SP_MEM;
    case (cmd_be_n)
      4'b0010, 4'b0011: begin cmd_ok = 1'b1; cmd_sp = SP_IO; end
      4'b1010, 4'b1011: begin cmd_ok = 1'b1; cmd_sp = SP_CFG; end
      4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: cmd_ok = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NREG - 1; i >= 0; i--)
      if (region_hit[i]) hit_idx = RW'(i);
  end

  assign addr_phase = (st == S_IDLE) && frame_q && !bus_active_n;
  assign take       = addr_phase && cmd_ok && (|region_hit);
  assign no_burst   = (hit_idx < RW'(NOBURST)) || (cmd_sp == SP_MEM && addr_lo != 2'b00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      frame_q   <= 1'b1;
      disc_q    <= 1'b0;
      be_write  <= 1'b0;
      be_space  <= SP_MEM;
      be_region <= '0;
    end else begin
      frame_q <= bus_active_n;
      case (st)
        S_IDLE:
          if (take) begin
            st        <= S_DATA;
            disc_q    <= no_burst;
            be_write  <= cmd_be_n[0];
            be_space  <= cmd_sp;
            be_region <= hit_idx;
          end
        S_DATA:
          if (!init_ready_n) begin
            if (bus_active_n) st <= S_IDLE;
            else if (disc_q)  st <= S_HOLD;
          end
        S_HOLD:
          if (bus_active_n && !init_ready_n) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign owned       = (st != S_IDLE);
  assign tgt_ready_n = (st != S_DATA);
  assign disc_req_n  = !(owned && disc_q);
  assign be_strobe   = (st == S_DATA) && !init_ready_n;

  // R2
  bad_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !cmd_ok) |=> !owned);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !owned |-> (tgt_ready_n && disc_req_n && !be_strobe));

  // R10
  no_data_after_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disc_req_n && !tgt_ready_n && !init_ready_n && !bus_active_n) |=> tgt_ready_n);

  // R10
  stop_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!disc_req_n && !bus_active_n) |=> !disc_req_n);

  // R11
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && bus_active_n && !init_ready_n) |=> !owned);

  // R6
  strobe_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_strobe |-> (!tgt_ready_n && !init_ready_n && owned));

endmodule

// File: tb/tb_pci_tgt_cmd_ctl.sv
`timescale 1ns/1ps
module tb_pci_tgt_cmd_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_active_n = 1'b1, init_ready_n = 1'b1;
  logic [3:0] cmd_be_n = 4'h0;
  logic [1:0] addr_lo = 2'b00;
  logic [6:0] region_hit = '0;
  logic owned, tgt_ready_n, disc_req_n, be_strobe, be_write;
  logic [1:0] be_space;
  logic [2:0] be_region;
  int compared = 0, mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pci_tgt_cmd_ctl dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cmd %b hit %b alo %b)",
               req, what, act, exp, cmd_be_n, region_hit, addr_lo);
    end
  endtask

  function automatic bit is_claimed(logic [3:0] c);
    case (c)
      4'b0010, 4'b0011, 4'b0110, 4'b0111, 4'b1010, 4'b1011,
      4'b1100, 4'b1110, 4'b1111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int space_of(logic [3:0] c);
    if (c == 4'b0010 || c == 4'b0011) return 1;
    if (c == 4'b1010 || c == 4'b1011) return 2;
    return 0;
  endfunction

  task automatic run_cycle(logic [3:0] c, logic [6:0] hit, logic [1:0] alo, int nph);
    bit cl, disc;
    int idx, sp;
    string rq;
    idx = 0;
    for (int i = 6; i >= 0; i--) if (hit[i]) idx = i;
    sp   = space_of(c);
    cl   = is_claimed(c) && (hit != 0);
    disc = (idx < 3) || (sp == 0 && alo != 2'b00);
    rq   = !is_claimed(c) ? "R2" : (hit == 0) ? "R5" : (idx < 3) ? "R8" :
           disc ? "R9" : "R7";
    @(negedge clk);
    bus_active_n = 1'b0; init_ready_n = 1'b1;
    cmd_be_n = c; region_hit = hit; addr_lo = alo;
    @(negedge clk);
    cmd_be_n = ~c; region_hit = '0; addr_lo = ~alo;
    chk(is_claimed(c) ? "R1" : "R2", "owned", owned, cl);
    if (alo == 2'b01) begin
      #1;
      chk(rq, "wait ready", tgt_ready_n, !cl);
      chk("R6", "wait strobe", be_strobe, 0);
      @(negedge clk);
    end
    for (int k = 0; k < nph; k++) begin
      bit rdy;
      init_ready_n = 1'b0;
      bus_active_n = (k == nph - 1);
      #1;
      rdy = cl && (k == 0 || !disc);
      if (k > 0 && cl && disc) rq = "R10";
      chk(rq, "ready", tgt_ready_n, !rdy);
      chk(rq, "stop", disc_req_n, !(cl && disc));
      chk("R6", "strobe", be_strobe, rdy);
      if (rdy) begin
        chk(c[3:2] == 2'b11 ? (c[0] ? "R4" : "R3") : "R6", "write", be_write, c[0]);
        chk(c[3:2] == 2'b11 ? (c[0] ? "R4" : "R3") : "R6", "space", be_space, sp);
        chk("R5", "region", be_region, idx);
      end
      @(negedge clk);
    end
    bus_active_n = 1'b1; init_ready_n = 1'b1;
    #1;
    chk("R11", "owned after", owned, 0);
    chk("R11", "ready after", tgt_ready_n, 1);
    chk("R11", "stop after", disc_req_n, 1);
    @(negedge clk);
  endtask

  initial begin
    logic [6:0] hits [10];
    hits[0] = 7'b0; hits[8] = 7'b1001000; hits[9] = 7'b0100010;
    for (int i = 0; i < 7; i++) hits[i + 1] = 7'(1 << i);
    #1;
    chk("R11", "reset owned", owned, 0);
    chk("R11", "reset ready", tgt_ready_n, 1);
    chk("R11", "reset stop", disc_req_n, 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 16; c++)
      for (int h = 0; h < 10; h++)
        for (int a = 0; a < 3; a++)
          for (int n = 1; n <= 3; n += 2)
            run_cycle(4'(c), hits[h], 2'(a), n);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule